// File: doc/BRIEF.md
# Compare-Event Pin Action Controller

This block decides what happens to up to eight timer output pins when their compare channels fire. Each channel holds a two-bit action code (do nothing, invert, drive low, drive high). When the channel's single-cycle match strobe arrives, the channel's output latch is updated one clock edge later according to that code. Any non-zero code also claims the pin as an output, so the block drives a per-channel output enable next to the latch value.

The action codes sit in two 8-bit registers on a simple synchronous register bus. The bus can read and write them at any time. The free-running counter and the comparators are outside the block, as is the path that lets channel 7 drive several pins at once. Their effects arrive as three per-channel input vectors:
- the match strobes;
- an override mask, which suppresses a channel's own action;
- a disconnect vector, which detaches a channel from its pin.

Top module: `oc_pin_action`

## Requirements
- R1: Channel c's code is two bits, an upper "mode" bit and a lower "level" bit. The register at offset 0x08 holds channels 7,6,5,4 in bit pairs [7:6],[5:4],[3:2],[1:0], and the register at offset 0x09 holds channels 3,2,1,0 in the same pair positions.
- R2: Code 00 means no action. A strobe leaves that channel's latch unchanged and the channel's output enable stays 0.
- R3: Code 01 inverts the channel's latch on the clock edge that samples the strobe. The new value is visible after that edge.
- R4: Code 10 drives the latch to 0 and code 11 drives it to 1, with the same timing as R3.
- R5: A channel's output enable is 1 exactly when its code is non-zero, its override-mask bit is 0 and its disconnect bit is 0. The enable is combinational in the same cycle.
- R6: When a channel's override-mask bit is 1, a strobe leaves its latch unchanged.
- R7: When a channel's disconnect bit is 1 (and its mask bit is 0), a strobe still updates its latch as in R3/R4, but the channel's output enable is 0.
- R8: Synchronous active-high reset clears both code registers, all latches and the read-data register.
- R9: When a register write and a strobe fall in the same cycle, the strobe uses the code held before the write. The written code acts from the next cycle on.
- R10: The bus address is sampled every cycle. The read-data output shows that register's stored byte (its value before any write in the same cycle) after the next clock edge.
- R11: Offsets other than 0x08 and 0x09 read as zero, and writes to them change no stored code.
- R12: A channel whose strobe is 0 keeps its latch value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for the previous cycle's address |
| cmp_hit | input | 8 | Per-channel compare-match strobes |
| ovr_mask | input | 8 | Per-channel override mask; 1 suppresses the channel's action |
| pin_disc | input | 8 | Per-channel pin disconnect; 1 detaches the pin |
| pin_val | output | 8 | Per-channel output latch values |
| pin_oe | output | 8 | Per-channel pin output enables |

## Verification
On every cycle, assertions in each channel check the latch transition for every code:
- an inversion follows a toggle strobe;
- a forced level follows a clear or set strobe;
- the latch holds under code 00, a set mask bit or an absent strobe.

Assertions in the register file check the following on every cycle:
- a write to a valid offset lands;
- a write to any other offset changes nothing;
- a read of such an offset returns zero.

Only the bench's scenarios can show three things: the bit-pair mapping of channels to register positions, the gating of the output enable by mask and disconnect, and the use of the pre-write code when a write and a strobe meet in one cycle. The bench shows these by comparing against a behavioural model.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } oc_act_e;
endpackage

// File: rtl/oc_code_regs.sv
module oc_code_regs #(
  parameter int NCH  = 8,
  parameter int DW   = 8,
  parameter int AW   = 4,
  parameter int BASE = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   addr,
  input  logic            wr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic [2*NCH-1:0] codes
);
  localparam int NREG = (2 * NCH) / DW;

  logic [DW-1:0]   regs  [NREG];
  logic [NREG-1:0] sel;
  logic            addr_ok;
  logic [DW-1:0]   rd_mux;

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    assign sel[k] = (addr == AW'(BASE + k));

    always_ff @(posedge clk) begin
      if (rst) regs[k] <= '0;
      else if (wr && sel[k]) regs[k] <= wdata;
    end

    // highest channels live in the lowest offset
    assign codes[2*NCH-1-DW*k -: DW] = regs[k];

    assert_wr_lands_R1: assert property (@(posedge clk) disable iff (rst)
      (wr && sel[k]) |=> (regs[k] == $past(wdata)));
  end

  assign addr_ok = |sel;

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NREG; k++)
      if (sel[k]) rd_mux = regs[k];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  assert_unused_wr_R11: assert property (@(posedge clk) disable iff (rst)
    (wr && !addr_ok) |=> $stable(codes));
  assert_unused_rd_R11: assert property (@(posedge clk) disable iff (rst)
    !addr_ok |=> (rdata == '0));
  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (codes == '0 && rdata == '0));
endmodule

// File: rtl/oc_chan.sv
module oc_chan
  import oc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  oc_act_e code,
  input  logic    hit,
  input  logic    mask,
  input  logic    disc,
  output logic    val,
  output logic    oe
);
  logic nxt;

  always_comb begin
    nxt = val;
    if (hit && !mask) begin
      unique case (code)
        ACT_TOGGLE: nxt = ~val;
        ACT_CLEAR:  nxt = 1'b0;
        ACT_SET:    nxt = 1'b1;
        default:    nxt = val;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) val <= 1'b0;
    else     val <= nxt;
  end

  assign oe = (code != ACT_NONE) && !mask && !disc;

  assert_none_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (hit && code == ACT_NONE) |=> $stable(val));
  assert_toggle_R3: assert property (@(posedge clk) disable iff (rst)
    (hit && !mask && code == ACT_TOGGLE) |=> (val != $past(val)));
  assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (hit && !mask && code == ACT_CLEAR) |=> !val);
  assert_set_R4: assert property (@(posedge clk) disable iff (rst)
    (hit && !mask && code == ACT_SET) |=> val);
  assert_mask_holds_R6: assert property (@(posedge clk) disable iff (rst)
    mask |=> $stable(val));
  assert_idle_holds_R12: assert property (@(posedge clk) disable iff (rst)
    !hit |=> $stable(val));
  assert_reset_low_R8: assert property (@(posedge clk)
    rst |=> !val);
endmodule

// File: rtl/oc_pin_action.sv
module oc_pin_action
  import oc_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int DW   = 8,
  parameter int AW   = 4,
  parameter int BASE = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [AW-1:0]  bus_addr,
  input  logic           bus_wr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  input  logic [NCH-1:0] cmp_hit,
  input  logic [NCH-1:0] ovr_mask,
  input  logic [NCH-1:0] pin_disc,
  output logic [NCH-1:0] pin_val,
  output logic [NCH-1:0] pin_oe
);
  logic [2*NCH-1:0] codes;

  oc_code_regs #(.NCH(NCH), .DW(DW), .AW(AW), .BASE(BASE)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .addr  (bus_addr),
    .wr    (bus_wr),
    .wdata (bus_wdata),
    .rdata (bus_rdata),
    .codes (codes)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    oc_chan u_ch (
      .clk  (clk),
      .rst  (rst),
      .code (oc_act_e'(codes[2*c+1 -: 2])),
      .hit  (cmp_hit[c]),
      .mask (ovr_mask[c]),
      .disc (pin_disc[c]),
      .val  (pin_val[c]),
      .oe   (pin_oe[c])
    );
  end

  assert_oe_needs_connect_R7: assert property (@(posedge clk) disable iff (rst)
    (pin_oe & (pin_disc | ovr_mask)) == '0);
endmodule

// File: tb/sim_oc_pin_action.sv
`timescale 1ns/1ps
module sim_oc_pin_action;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] cmp_hit = '0, ovr_mask = '0, pin_disc = '0;
  logic [7:0] pin_val, pin_oe;

  int checks = 0;
  int errors = 0;
  int mcode [8];
  logic [7:0] mval = '0;

  always #2 clk = ~clk;

  oc_pin_action u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_hit(cmp_hit),
    .ovr_mask(ovr_mask), .pin_disc(pin_disc), .pin_val(pin_val), .pin_oe(pin_oe)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mread(input logic [3:0] a);
    logic [7:0] r = '0;
    if (a == 4'h8) for (int i = 0; i < 4; i++) r[7-2*i -: 2] = 2'(mcode[7-i]);
    if (a == 4'h9) for (int i = 0; i < 4; i++) r[7-2*i -: 2] = 2'(mcode[3-i]);
    return r;
  endfunction

  task automatic step(input logic [3:0] a, input logic w, input logic [7:0] d,
                      input logic [7:0] h, input logic [7:0] m, input logic [7:0] p,
                      input string tag);
    logic [7:0] eoe;
    logic [7:0] erd;
    bus_addr = a; bus_wr = w; bus_wdata = d;
    cmp_hit = h; ovr_mask = m; pin_disc = p;
    #1;
    for (int c = 0; c < 8; c++) eoe[c] = (mcode[c] != 0) && !m[c] && !p[c];
    chk({tag, " R5 oe"}, pin_oe, eoe);
    @(posedge clk);
    for (int c = 0; c < 8; c++)
      if (h[c] && !m[c])
        case (mcode[c])
          1: mval[c] = ~mval[c];
          2: mval[c] = 1'b0;
          3: mval[c] = 1'b1;
          default: ;
        endcase
    erd = mread(a);
    if (w && a == 4'h8) for (int i = 0; i < 4; i++) mcode[7-i] = int'(d[7-2*i -: 2]);
    if (w && a == 4'h9) for (int i = 0; i < 4; i++) mcode[3-i] = int'(d[7-2*i -: 2]);
    @(negedge clk);
    chk({tag, " latch"}, pin_val, mval);
    chk({tag, " R10 rdata"}, bus_rdata, erd);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 8; c++) mcode[c] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R8 reset latch", pin_val, 8'h00);
    chk("R8 reset oe", pin_oe, 8'h00);
    step(4'h8, 0, 8'h00, 8'hFF, 8'h00, 8'h00, "R8 R2 reg8 zero");
    step(4'h9, 0, 8'h00, 8'h00, 8'h00, 8'h00, "R8 reg9 zero");
    // ch7 none, ch6 toggle, ch5 clear, ch4 set | ch3 set, ch2 clear, ch1 toggle, ch0 none
    step(4'h8, 1, 8'h1B, 8'h00, 8'h00, 8'h00, "R1 wr8");
    step(4'h9, 1, 8'hE4, 8'h00, 8'h00, 8'h00, "R1 wr9");
    step(4'h8, 0, 8'h00, 8'h00, 8'h00, 8'h00, "R1 R10 rd8");
    step(4'h9, 0, 8'h00, 8'h00, 8'h00, 8'h00, "R1 R10 rd9");
    chk("R1 ch4 set code drives oe", pin_oe & 8'h10, 8'h10);
    step(4'h8, 0, 8'h00, 8'hFF, 8'h00, 8'h00, "R2 R3 R4 hit all");
    chk("R4 set/clear levels", pin_val & 8'h3C, 8'h18);
    step(4'h8, 0, 8'h00, 8'hFF, 8'h00, 8'h00, "R3 hit again");
    step(4'h8, 0, 8'h00, 8'h42, 8'h00, 8'h00, "R3 toggles only");
    repeat (3) step(4'h9, 0, 8'h00, 8'h00, 8'h00, 8'h00, "R12 idle");
    step(4'h8, 0, 8'h00, 8'hFF, 8'h0F, 8'h00, "R6 mask low");
    step(4'h8, 0, 8'h00, 8'hFF, 8'hF0, 8'h00, "R6 mask high");
    step(4'h8, 0, 8'h00, 8'hFF, 8'h00, 8'hF0, "R7 disc high");
    step(4'h8, 0, 8'h00, 8'hFF, 8'h00, 8'h0F, "R7 disc low");
    step(4'h8, 0, 8'h00, 8'h00, 8'h5A, 8'hA5, "R5 mixed gates");
    step(4'h8, 1, 8'h00, 8'hFF, 8'h00, 8'h00, "R9 write with hit");
    step(4'h8, 0, 8'h00, 8'hFF, 8'h00, 8'h00, "R9 new code");
    step(4'h9, 1, 8'h55, 8'h0F, 8'h00, 8'h00, "R9 wr9 with hit");
    step(4'h9, 0, 8'h00, 8'h0F, 8'h00, 8'h00, "R9 toggle after write");
    step(4'hA, 1, 8'hFF, 8'h00, 8'h00, 8'h00, "R11 unused wr");
    step(4'hA, 0, 8'h00, 8'h00, 8'h00, 8'h00, "R11 unused rd");
    step(4'h0, 1, 8'hFF, 8'h00, 8'h00, 8'h00, "R11 offset0 wr");
    step(4'h8, 0, 8'h00, 8'h00, 8'h00, 8'h00, "R11 reg8 intact");
    step(4'h9, 0, 8'h00, 8'h00, 8'h00, 8'h00, "R11 reg9 intact");
    step(4'h8, 1, 8'hFF, 8'h00, 8'h00, 8'h00, "R4 all set");
    step(4'h9, 1, 8'hAA, 8'hFF, 8'h00, 8'h00, "R4 set hit");
    step(4'h9, 0, 8'h00, 8'hFF, 8'h00, 8'h00, "R4 clear hit");
    chk("R4 levels", pin_val, 8'hF0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule